// File: doc/BRIEF.md
# Banked Bit-Addressable Data RAM

This block is the 128-byte internal data memory of an 8-bit microcontroller core. A single byte array is reached through three views. The byte port reads and writes any location by its 7-bit address. The register port reaches the lowest 32 bytes through a 3-bit register index and a 2-bit bank select. The bank select is driven from the core's status word and is not stored here. The bit port reaches the 128 bits of the 16-byte window at 20h–2Fh by a 7-bit bit address. It can read one bit, or set, clear or write it by read-modify-write.

Reads on all three ports are combinational from the stored array. Writes land on the rising clock edge. When two views write the same byte in one cycle, a fixed priority decides which one lands. The array contents are undefined after reset. Software or the bench must write a location before relying on it.

Top module: `banked_bit_ram`

## Requirements
- R1: A register access with bank select b and index i reaches byte address 8*b + i. A register write is then visible on the byte port at that address.
- R2: The bank select is not stored. Changing it alone changes the register read data in the same cycle, with no write.
- R3: Bit address n selects bit (n mod 8) of byte 20h + floor(n/8). For example, bit 0Bh is bit 3 of byte 21h and bit 7Fh is bit 7 of byte 2Fh. The bit read data returns that bit.
- R4: The bit operation code is 2 bits: 00 no operation, 01 set to 1, 10 clear to 0, 11 write the bit write value.
- R5: A bit set, clear or write changes only the addressed bit. The other seven bits of that byte keep their values.
- R6: A write is invisible on the read ports before the clock edge and visible in the cycle after it.
- R7: When a byte write and a bit operation hit the same byte in one cycle, the byte data is stored and the bit operation is dropped.
- R8: When the byte port and the register port write the same address in one cycle, the byte port data is stored.
- R9: Bytes 30h–7Fh, including 7Fh, act as plain storage with no aliasing to other addresses.
- R10: A register write and a bit operation to different bytes in the same cycle both take effect.
- R11: Bit operation code 00 leaves the addressed byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| byte_addr | input | 7 | Byte port address |
| byte_we | input | 1 | Byte port write enable |
| byte_wdata | input | 8 | Byte port write data |
| byte_rdata | output | 8 | Byte port read data |
| reg_idx | input | 3 | Register index within a bank |
| bank_sel | input | 2 | Bank select from the status word |
| reg_we | input | 1 | Register port write enable |
| reg_wdata | input | 8 | Register port write data |
| reg_rdata | output | 8 | Register port read data |
| bit_addr | input | 7 | Bit address |
| bit_op | input | 2 | Bit operation code |
| bit_wval | input | 1 | Value for the bit write operation |
| bit_rdata | output | 1 | Addressed bit |

## Verification
The hardest cases to reach are same-cycle collisions between views. These need two ports aimed at one physical byte through different address translations. The bench drives all three ports from one task in a single cycle. It picks a byte address and a bit address that decode to the same byte, and a byte address equal to a bank-times-eight-plus-index pair. It then reads the byte back through the plain port.

// File: rtl/ram_pkg.sv
package ram_pkg;
    localparam int ADDR_W   = 7;
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int DATA_W   = 8;
    localparam int BANK_W   = 2;
    localparam int IDX_W    = 3;
    localparam int POS_W    = $clog2(DATA_W);
    localparam int BITA_W   = 7;
    localparam logic [ADDR_W-1:0] BIT_BASE = 7'h20;

    typedef enum logic [1:0] {
        BOP_NONE  = 2'b00,
        BOP_SET   = 2'b01,
        BOP_CLR   = 2'b10,
        BOP_WRITE = 2'b11
    } bit_op_e;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // apply a single-bit operation to a byte, mask has exactly one bit set
    function automatic byte_t apply_bit_op(byte_t cur, byte_t mask,
                                           bit_op_e op, logic wval);
        byte_t res;
        case (op)
            BOP_SET:   res = cur | mask;
            BOP_CLR:   res = cur & ~mask;
            BOP_WRITE: res = wval ? (cur | mask) : (cur & ~mask);
            default:   res = cur;
        endcase
        return res;
    endfunction
endpackage

// File: rtl/ram_xlate.sv
module ram_xlate
    import ram_pkg::*;
(
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic [BITA_W-1:0] bit_addr,
    output addr_t             reg_addr,
    output addr_t             bit_byte,
    output logic [POS_W-1:0]  bit_pos,
    output byte_t             bit_mask
);
    localparam int PAD_R = ADDR_W - BANK_W - IDX_W;
    localparam int OFS_W = BITA_W - POS_W;

    // register view: bank selects a block of 2**IDX_W bytes from address 0
    assign reg_addr = {{PAD_R{1'b0}}, bank_sel, reg_idx};

    // bit view: upper bits pick the byte in the window, lower bits the position
    assign bit_byte = BIT_BASE + addr_t'(bit_addr[BITA_W-1:POS_W]);
    assign bit_pos  = bit_addr[POS_W-1:0];
    assign bit_mask = byte_t'(1) << bit_pos;

    // the bit window is 16 bytes wide; offset field width must match
    initial begin
        assert (OFS_W == 4) else $error("bit window width mismatch");
    end
endmodule

// File: rtl/ram_cell.sv
module ram_cell
    import ram_pkg::*;
(
    input  logic    clk,
    input  logic    byte_hit,
    input  byte_t   byte_data,
    input  logic    reg_hit,
    input  byte_t   reg_data,
    input  logic    bit_hit,
    input  byte_t   bit_mask,
    input  bit_op_e bit_op,
    input  logic    bit_wval,
    output byte_t   q
);
    byte_t nxt;

    // priority: byte port, then register port, then bit operation
    always_comb begin
        if (byte_hit)
            nxt = byte_data;
        else if (reg_hit)
            nxt = reg_data;
        else if (bit_hit)
            nxt = apply_bit_op(q, bit_mask, bit_op, bit_wval);
        else
            nxt = q;
    end

    always_ff @(posedge clk) begin
        q <= nxt;
    end
endmodule

// File: rtl/banked_bit_ram.sv
module banked_bit_ram
    import ram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic              byte_we,
    input  logic [DATA_W-1:0] byte_wdata,
    output logic [DATA_W-1:0] byte_rdata,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [BITA_W-1:0] bit_addr,
    input  logic [1:0]        bit_op,
    input  logic              bit_wval,
    output logic              bit_rdata
);
    addr_t            reg_addr;
    addr_t            bit_byte;
    logic [POS_W-1:0] bit_pos;
    byte_t            bit_mask;
    bit_op_e          op;
    byte_t            mem [DEPTH];

    assign op = bit_op_e'(bit_op);

    ram_xlate u_xlate (
        .reg_idx  (reg_idx),
        .bank_sel (bank_sel),
        .bit_addr (bit_addr),
        .reg_addr (reg_addr),
        .bit_byte (bit_byte),
        .bit_pos  (bit_pos),
        .bit_mask (bit_mask)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        ram_cell u_cell (
            .clk       (clk),
            .byte_hit  (byte_we && (byte_addr == addr_t'(g))),
            .byte_data (byte_wdata),
            .reg_hit   (reg_we && (reg_addr == addr_t'(g))),
            .reg_data  (reg_wdata),
            .bit_hit   ((op != BOP_NONE) && (bit_byte == addr_t'(g))),
            .bit_mask  (bit_mask),
            .bit_op    (op),
            .bit_wval  (bit_wval),
            .q         (mem[g])
        );
    end

    assign byte_rdata = mem[byte_addr];
    assign reg_rdata  = mem[reg_addr];
    assign bit_rdata  = mem[bit_byte][bit_pos];

    // ---------------- assertions ----------------
    logic bit_clean;
    assign bit_clean = (op != BOP_NONE)
                    && !(byte_we && byte_addr == bit_byte)
                    && !(reg_we && reg_addr == bit_byte);

    assert_reg_write_R1: assert property (@(posedge clk) disable iff (rst)
        (reg_we && !(byte_we && byte_addr == reg_addr))
        |=> mem[$past(reg_addr)] == $past(reg_wdata));

    assert_bit_set_R4: assert property (@(posedge clk) disable iff (rst)
        (bit_clean && op == BOP_SET)
        |=> (mem[$past(bit_byte)] & $past(bit_mask)) != '0);

    assert_bit_others_R5: assert property (@(posedge clk) disable iff (rst)
        bit_clean
        |=> ((mem[$past(bit_byte)] ^ $past(mem[bit_byte])) & ~$past(bit_mask)) == '0);

    assert_byte_over_bit_R7: assert property (@(posedge clk) disable iff (rst)
        (byte_we && op != BOP_NONE && byte_addr == bit_byte)
        |=> mem[$past(byte_addr)] == $past(byte_wdata));

    assert_byte_over_reg_R8: assert property (@(posedge clk) disable iff (rst)
        (byte_we && reg_we && byte_addr == reg_addr)
        |=> mem[$past(byte_addr)] == $past(byte_wdata));
endmodule

// File: tb/test_banked_bit_ram.sv
module test_banked_bit_ram;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] byte_addr = '0;
    logic       byte_we = 1'b0;
    logic [7:0] byte_wdata = '0;
    logic [7:0] byte_rdata;
    logic [2:0] reg_idx = '0;
    logic [1:0] bank_sel = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [6:0] bit_addr = '0;
    logic [1:0] bit_op = 2'b00;
    logic       bit_wval = 1'b0;
    logic       bit_rdata;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    banked_bit_ram i_banked_bit_ram (
        .clk(clk), .rst(rst),
        .byte_addr(byte_addr), .byte_we(byte_we), .byte_wdata(byte_wdata),
        .byte_rdata(byte_rdata),
        .reg_idx(reg_idx), .bank_sel(bank_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bit_addr(bit_addr), .bit_op(bit_op), .bit_wval(bit_wval),
        .bit_rdata(bit_rdata)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // one cycle of simultaneous stimulus on all three ports
    task automatic drive(input logic bwe, input logic [6:0] ba, input logic [7:0] bd,
                         input logic rwe, input logic [1:0] bk, input logic [2:0] ri,
                         input logic [7:0] rd,
                         input logic [1:0] op, input logic [6:0] bta, input logic wv);
        @(negedge clk);
        byte_we = bwe; byte_addr = ba; byte_wdata = bd;
        reg_we = rwe; bank_sel = bk; reg_idx = ri; reg_wdata = rd;
        bit_op = op; bit_addr = bta; bit_wval = wv;
        @(posedge clk);
        #1;
        byte_we = 1'b0; reg_we = 1'b0; bit_op = 2'b00;
    endtask

    task automatic wr_byte(input logic [6:0] a, input logic [7:0] d);
        drive(1'b1, a, d, 1'b0, 2'd0, 3'd0, 8'h00, 2'b00, 7'h00, 1'b0);
    endtask

    task automatic bit_do(input logic [1:0] op, input logic [6:0] n, input logic wv);
        drive(1'b0, 7'h00, 8'h00, 1'b0, 2'd0, 3'd0, 8'h00, op, n, wv);
    endtask

    task automatic rd_byte(input logic [6:0] a, output logic [7:0] v);
        @(negedge clk);
        byte_addr = a;
        #1;
        v = byte_rdata;
    endtask

    task automatic t_after_reset();
        logic [7:0] v;
        drive(1'b0, 7'h00, 8'h00, 1'b1, 2'd0, 3'd0, 8'h5A, 2'b00, 7'h00, 1'b0);
        rd_byte(7'h00, v);
        check("R1 bank0 idx0 after reset", v, 8'h5A);
    endtask

    task automatic t_banks();
        logic [7:0] v;
        for (int b = 0; b < 4; b++) begin
            for (int k = 0; k < 2; k++) begin
                drive(1'b0, 7'h00, 8'h00, 1'b1, 2'(b), 3'(k * 7), 8'(8'hC0 + b * 8 + k * 7),
                      2'b00, 7'h00, 1'b0);
            end
        end
        for (int b = 0; b < 4; b++) begin
            for (int k = 0; k < 2; k++) begin
                rd_byte(7'(b * 8 + k * 7), v);
                check("R1 register to byte mapping", v, 8'(8'hC0 + b * 8 + k * 7));
            end
        end
        // R2: switch bank alone, register read follows
        @(negedge clk);
        reg_idx = 3'd7;
        bank_sel = 2'd1;
        #1;
        check("R2 bank1 idx7 read", reg_rdata, 8'hCF);
        bank_sel = 2'd3;
        #1;
        check("R2 bank3 idx7 read no write", reg_rdata, 8'hDF);
    endtask

    task automatic t_bit_map();
        logic [7:0] v;
        wr_byte(7'h21, 8'h00);
        wr_byte(7'h2F, 8'h00);
        bit_do(2'b01, 7'h0B, 1'b0);
        rd_byte(7'h21, v);
        check("R3 bit 0Bh is byte 21h bit3", v, 8'h08);
        @(negedge clk);
        bit_addr = 7'h0B;
        #1;
        check("R3 bit read 0Bh", {7'b0, bit_rdata}, 8'h01);
        bit_addr = 7'h0C;
        #1;
        check("R3 bit read 0Ch", {7'b0, bit_rdata}, 8'h00);
        bit_do(2'b01, 7'h7F, 1'b0);
        rd_byte(7'h2F, v);
        check("R3 bit 7Fh is byte 2Fh bit7", v, 8'h80);
    endtask

    task automatic t_bit_ops();
        logic [7:0] v;
        wr_byte(7'h25, 8'hA5);
        bit_do(2'b10, 7'h28, 1'b0);
        rd_byte(7'h25, v);
        check("R4 R5 clear bit0", v, 8'hA4);
        bit_do(2'b01, 7'h2E, 1'b0);
        rd_byte(7'h25, v);
        check("R4 R5 set bit6", v, 8'hE4);
        bit_do(2'b11, 7'h2F, 1'b0);
        rd_byte(7'h25, v);
        check("R4 R5 write 0 bit7", v, 8'h64);
        bit_do(2'b11, 7'h29, 1'b1);
        rd_byte(7'h25, v);
        check("R4 R5 write 1 bit1", v, 8'h66);
        bit_do(2'b00, 7'h2A, 1'b1);
        rd_byte(7'h25, v);
        check("R11 no-op leaves byte", v, 8'h66);
    endtask

    task automatic t_timing();
        logic [7:0] v;
        wr_byte(7'h40, 8'h22);
        @(negedge clk);
        byte_we = 1'b1; byte_addr = 7'h40; byte_wdata = 8'h11;
        #1;
        check("R6 old value before edge", byte_rdata, 8'h22);
        @(posedge clk);
        #1;
        byte_we = 1'b0;
        rd_byte(7'h40, v);
        check("R6 new value after edge", v, 8'h11);
    endtask

    task automatic t_collisions();
        logic [7:0] v;
        wr_byte(7'h22, 8'h00);
        drive(1'b1, 7'h22, 8'hF0, 1'b0, 2'd0, 3'd0, 8'h00, 2'b01, 7'h10, 1'b0);
        rd_byte(7'h22, v);
        check("R7 byte write beats bit set", v, 8'hF0);
        drive(1'b1, 7'h0A, 8'h33, 1'b1, 2'd1, 3'd2, 8'h44, 2'b00, 7'h00, 1'b0);
        rd_byte(7'h0A, v);
        check("R8 byte write beats register write", v, 8'h33);
        wr_byte(7'h20, 8'h00);
        drive(1'b0, 7'h00, 8'h00, 1'b1, 2'd3, 3'd5, 8'h77, 2'b01, 7'h00, 1'b0);
        rd_byte(7'h1D, v);
        check("R10 register write lands", v, 8'h77);
        rd_byte(7'h20, v);
        check("R10 bit set lands", v, 8'h01);
    endtask

    task automatic t_scratch();
        logic [7:0] v;
        wr_byte(7'h30, 8'h01);
        wr_byte(7'h7F, 8'hFE);
        wr_byte(7'h55, 8'h3C);
        rd_byte(7'h30, v);
        check("R9 scratch 30h", v, 8'h01);
        rd_byte(7'h7F, v);
        check("R9 scratch 7Fh", v, 8'hFE);
        rd_byte(7'h55, v);
        check("R9 scratch 55h", v, 8'h3C);
        rd_byte(7'h40, v);
        check("R9 no aliasing at 40h", v, 8'h11);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        t_after_reset();
        t_banks();
        t_bit_map();
        t_bit_ops();
        t_timing();
        t_collisions();
        t_scratch();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule